// File: doc/BRIEF.md
# Page Register Address Translator

This block maps a CPU logical address to a physical address through a bank of on-chip page registers. There is one register for every possible page number. The upper bits of the logical address select a register. That register supplies a frame number, a valid flag and three permission bits (read, write, fetch). The physical address is the selected frame number placed above the untouched lower displacement bits. The result appears on the output one clock after the request.

Software rewrites the bank through a write port, for example when it switches context. A flush input marks every entry invalid in a single cycle. The block reports a reference to an invalid entry on one flag and an access type that the entry does not permit on another flag. In either case it issues no physical address.

Top module: `pxu_top`

## Requirements
- R1: After reset every output is low and every entry is invalid, so a request before any load reports a page fault.
- R2: A request to a valid, permitted page gives pa_vld_o high one cycle later. pa_o then equals the entry's frame number in the upper bits and the request's lower LA_W-PN_W address bits below it.
- R3: A request whose entry is invalid gives page_fault_o high one cycle later, with pa_vld_o low and pa_o zero.
- R4: Access codes are 0 read, 1 write and 2 fetch. They need permission bits 0, 1 and 2 of the entry respectively. A valid entry without the needed bit gives prot_fault_o high one cycle later and pa_vld_o low.
- R5: Access code 3 is reserved. On a valid entry it always gives prot_fault_o.
- R6: A cycle without req_i gives all three strobes low in the following cycle.
- R7: A register write takes effect for requests in later cycles. A request in the same cycle as the write sees the old entry.
- R8: flush_i clears every valid bit. A register write in the same cycle as a flush is dropped.
- R9: At most one of pa_vld_o, page_fault_o and prot_fault_o is high in any cycle.
- R10: An invalid entry reports a page fault and not a protection fault, whatever its permission bits hold.
- R11: pa_o is zero whenever pa_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| la_i | input | LA_W | Logical address |
| wr_en_i | input | 1 | Page register write enable |
| wr_idx_i | input | PN_W | Page register index to write |
| wr_frame_i | input | FRAME_W | Frame number to load |
| wr_valid_i | input | 1 | Valid flag to load |
| wr_perm_i | input | 3 | Permissions to load: bit 0 read, bit 1 write, bit 2 fetch |
| flush_i | input | 1 | Clear all valid flags |
| pa_o | output | FRAME_W+LA_W-PN_W | Physical address |
| pa_vld_o | output | 1 | Physical address valid strobe |
| page_fault_o | output | 1 | Invalid page trap |
| prot_fault_o | output | 1 | Access type refused trap |

## Verification
The bench builds the block with its defaults: a 16-bit logical address, a 4-bit page number (4 KiB pages) and an 8-bit frame number. With only sixteen entries, a directed sequence can reach the first and last page, the all-ones displacement and every permission pattern. A long random run then hits same-cycle write/request and flush/write collisions many times over. The behavioural model in the bench predicts each output one cycle after its inputs and compares the result on every clock.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/pxu_regbank.sv
module pxu_regbank #(
  parameter int PN_W    = 4,
  parameter int FRAME_W = 8,
  localparam int N_PG   = 1 << PN_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [PN_W-1:0]                 wr_idx_i,
  input  logic [FRAME_W-1:0]              wr_frame_i,
  input  logic                            wr_valid_i,
  input  pxu_pkg::perm_t                  wr_perm_i,
  input  logic                            flush_i,
  output logic [N_PG-1:0]                 valid_o,
  output logic [N_PG-1:0][FRAME_W-1:0]    frame_o,
  output pxu_pkg::perm_t [N_PG-1:0]       perm_o
);
  for (genvar i = 0; i < N_PG; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == PN_W'(i));

    // flush has priority; a colliding write is dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        frame_o[i] <= '0;
        perm_o[i]  <= '0;
      end else if (flush_i) begin
        valid_o[i] <= 1'b0;
      end else if (sel) begin
        valid_o[i] <= wr_valid_i;
        frame_o[i] <= wr_frame_i;
        perm_o[i]  <= wr_perm_i;
      end
    end
  end
endmodule

// File: rtl/pxu_lookup.sv
module pxu_lookup #(
  parameter int LA_W    = 16,
  parameter int PN_W    = 4,
  parameter int FRAME_W = 8,
  localparam int D_W    = LA_W - PN_W,
  localparam int PA_W   = FRAME_W + D_W,
  localparam int N_PG   = 1 << PN_W
) (
  input  logic [LA_W-1:0]                 la_i,
  input  pxu_pkg::acc_e                   acc_i,
  input  logic [N_PG-1:0]                 valid_i,
  input  logic [N_PG-1:0][FRAME_W-1:0]    frame_i,
  input  pxu_pkg::perm_t [N_PG-1:0]       perm_i,
  output logic [PA_W-1:0]                 pa_o,
  output logic                            ok_o,
  output logic                            pf_o,
  output logic                            prot_o
);
  logic [PN_W-1:0] pn;
  logic [D_W-1:0]  disp;
  pxu_pkg::perm_t  perm_sel;
  logic            allowed;

  assign pn       = la_i[LA_W-1 -: PN_W];
  assign disp     = la_i[D_W-1:0];
  assign perm_sel = perm_i[pn];

  always_comb begin
    unique case (acc_i)
      pxu_pkg::ACC_RD:    allowed = perm_sel.r;
      pxu_pkg::ACC_WR:    allowed = perm_sel.w;
      pxu_pkg::ACC_FETCH: allowed = perm_sel.x;
      default:            allowed = 1'b0;
    endcase
  end

  assign pf_o   = !valid_i[pn];
  assign prot_o = valid_i[pn] && !allowed;
  assign ok_o   = valid_i[pn] && allowed;
  assign pa_o   = {frame_i[pn], disp};
endmodule

// File: rtl/pxu_top.sv
module pxu_top #(
  parameter int LA_W    = 16,
  parameter int PN_W    = 4,
  parameter int FRAME_W = 8,
  localparam int D_W    = LA_W - PN_W,
  localparam int PA_W   = FRAME_W + D_W,
  localparam int N_PG   = 1 << PN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         acc_i,
  input  logic [LA_W-1:0]    la_i,
  input  logic               wr_en_i,
  input  logic [PN_W-1:0]    wr_idx_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  input  logic               wr_valid_i,
  input  logic [2:0]         wr_perm_i,
  input  logic               flush_i,
  output logic [PA_W-1:0]    pa_o,
  output logic               pa_vld_o,
  output logic               page_fault_o,
  output logic               prot_fault_o
);
  logic [N_PG-1:0]              ent_valid;
  logic [N_PG-1:0][FRAME_W-1:0] ent_frame;
  pxu_pkg::perm_t [N_PG-1:0]    ent_perm;
  logic [PA_W-1:0]              pa_c;
  logic                         ok_c, pf_c, prot_c;

  pxu_regbank #(.PN_W(PN_W), .FRAME_W(FRAME_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_frame_i (wr_frame_i),
    .wr_valid_i (wr_valid_i),
    .wr_perm_i  (pxu_pkg::perm_t'(wr_perm_i)),
    .flush_i    (flush_i),
    .valid_o    (ent_valid),
    .frame_o    (ent_frame),
    .perm_o     (ent_perm)
  );

  pxu_lookup #(.LA_W(LA_W), .PN_W(PN_W), .FRAME_W(FRAME_W)) u_lookup (
    .la_i    (la_i),
    .acc_i   (pxu_pkg::acc_e'(acc_i)),
    .valid_i (ent_valid),
    .frame_i (ent_frame),
    .perm_i  (ent_perm),
    .pa_o    (pa_c),
    .ok_o    (ok_c),
    .pf_o    (pf_c),
    .prot_o  (prot_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_o         <= '0;
      pa_vld_o     <= 1'b0;
      page_fault_o <= 1'b0;
      prot_fault_o <= 1'b0;
    end else begin
      pa_vld_o     <= req_i && ok_c;
      page_fault_o <= req_i && pf_c;
      prot_fault_o <= req_i && prot_c;
      pa_o         <= (req_i && ok_c) ? pa_c : '0;
    end
  end
endmodule

// File: rtl/pxu_sva.sv
module pxu_sva #(
  parameter int LA_W    = 16,
  parameter int PN_W    = 4,
  parameter int FRAME_W = 8,
  localparam int D_W    = LA_W - PN_W,
  localparam int PA_W   = FRAME_W + D_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [1:0]      acc_i,
  input logic [LA_W-1:0] la_i,
  input logic            flush_i,
  input logic [PA_W-1:0] pa_o,
  input logic            pa_vld_o,
  input logic            page_fault_o,
  input logic            prot_fault_o
);
  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pa_vld_o, page_fault_o, prot_fault_o}));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(pa_vld_o || page_fault_o || prot_fault_o));

  p_pa_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pa_vld_o |-> (pa_o == '0));

  p_disp_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!pa_vld_o || (pa_o[D_W-1:0] == $past(la_i[D_W-1:0]))));

  p_rsvd_refused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_i == 2'd3) |=> !pa_vld_o);

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i, 2) && $past(req_i)) |-> page_fault_o);
endmodule

bind pxu_top pxu_sva #(.LA_W(LA_W), .PN_W(PN_W), .FRAME_W(FRAME_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .acc_i        (acc_i),
  .la_i         (la_i),
  .flush_i      (flush_i),
  .pa_o         (pa_o),
  .pa_vld_o     (pa_vld_o),
  .page_fault_o (page_fault_o),
  .prot_fault_o (prot_fault_o)
);

// File: tb/tb_pxu_top.sv
module tb_pxu_top;
  localparam int LA_W = 16, PN_W = 4, FRAME_W = 8;
  localparam int D_W = LA_W - PN_W, PA_W = FRAME_W + D_W, N_PG = 1 << PN_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, wr_en_i = 0, wr_valid_i = 0, flush_i = 0;
  logic [1:0] acc_i = 0;
  logic [LA_W-1:0] la_i = 0;
  logic [PN_W-1:0] wr_idx_i = 0;
  logic [FRAME_W-1:0] wr_frame_i = 0;
  logic [2:0] wr_perm_i = 0;
  logic [PA_W-1:0] pa_o;
  logic pa_vld_o, page_fault_o, prot_fault_o;

  int checks = 0, errors = 0;
  bit m_v [N_PG];
  int m_frame [N_PG];
  int m_perm [N_PG];

  always #5 clk_i = ~clk_i;

  pxu_top #(.LA_W(LA_W), .PN_W(PN_W), .FRAME_W(FRAME_W)) dut (.*);

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  // outputs sampled 1 ns after the edge; model state updated after comparing
  task automatic step(input string tag);
    int pn, pm;
    bit allow;
    logic [PA_W-1:0] e_pa;
    bit e_v, e_pf, e_pr;
    @(posedge clk_i); #1;
    e_pa = '0; e_v = 0; e_pf = 0; e_pr = 0;
    if (req_i) begin
      pn = int'(la_i[LA_W-1 -: PN_W]);
      pm = m_perm[pn];
      case (acc_i)
        2'd0: allow = pm[0];
        2'd1: allow = pm[1];
        2'd2: allow = pm[2];
        default: allow = 0;
      endcase
      if (!m_v[pn]) e_pf = 1;
      else if (!allow) e_pr = 1;
      else begin
        e_v = 1;
        e_pa = {FRAME_W'(m_frame[pn]), la_i[D_W-1:0]};
      end
    end
    check({pa_o, pa_vld_o, page_fault_o, prot_fault_o} == {e_pa, e_v, e_pf, e_pr}, tag,
          $sformatf("pa=%h v=%b pf=%b pr=%b", pa_o, pa_vld_o, page_fault_o, prot_fault_o),
          $sformatf("pa=%h v=%b pf=%b pr=%b", e_pa, e_v, e_pf, e_pr));
    if (flush_i) foreach (m_v[i]) m_v[i] = 0;
    else if (wr_en_i) begin
      m_v[wr_idx_i] = wr_valid_i;
      m_frame[wr_idx_i] = int'(wr_frame_i);
      m_perm[wr_idx_i] = int'(wr_perm_i);
    end
    req_i = 0; wr_en_i = 0; flush_i = 0;
  endtask

  task automatic set_req(input logic [1:0] a, input logic [LA_W-1:0] la);
    req_i = 1; acc_i = a; la_i = la;
  endtask

  task automatic set_wr(input int idx, input int fr, input bit v, input logic [2:0] p);
    wr_en_i = 1; wr_idx_i = PN_W'(idx); wr_frame_i = FRAME_W'(fr); wr_valid_i = v; wr_perm_i = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R6 watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_v[i]) begin m_v[i] = 0; m_frame[i] = 0; m_perm[i] = 0; end
    #22;
    check({pa_o, pa_vld_o, page_fault_o, prot_fault_o} == '0, "R1 reset outputs",
          $sformatf("%h", {pa_o, pa_vld_o, page_fault_o, prot_fault_o}), "0");
    rst_ni = 1;
    @(negedge clk_i);
    set_req(2'd0, 16'h0123); step("R1 unloaded page faults");
    step("R6 idle");
    set_wr(0, 8'h12, 1, 3'b111); step("R7 load p0");
    set_wr(1, 8'h34, 1, 3'b001); step("R7 load p1");
    set_wr(2, 8'hAB, 1, 3'b100); step("R7 load p2");
    set_wr(15, 8'hFF, 1, 3'b011); step("R7 load p15");
    set_wr(3, 8'h55, 0, 3'b000); step("R7 load p3 invalid");
    set_req(2'd0, 16'h0ABC); step("R2 read p0");
    set_req(2'd2, 16'h0001); step("R2 fetch p0");
    set_req(2'd1, 16'h1004); step("R4 write read-only p1");
    set_req(2'd0, 16'h1FFF); step("R2 read p1");
    set_req(2'd2, 16'h2010); step("R2 fetch p2");
    set_req(2'd0, 16'h2010); step("R4 read fetch-only p2");
    set_req(2'd1, 16'hFFFF); step("R2 write last page all-ones disp");
    set_req(2'd2, 16'hF000); step("R4 fetch on p15");
    set_req(2'd3, 16'h0000); step("R5 reserved code on p0");
    set_req(2'd0, 16'h5000); step("R3 invalid p5");
    set_req(2'd3, 16'h3000); step("R10 invalid p3 reserved");
    set_wr(5, 8'h77, 1, 3'b001); set_req(2'd0, 16'h5100); step("R7 same-cycle write old entry");
    set_req(2'd0, 16'h5100); step("R7 write visible next cycle");
    flush_i = 1; set_wr(6, 8'h66, 1, 3'b111); set_req(2'd0, 16'h0000); step("R8 flush cycle sees old");
    set_req(2'd0, 16'h0000); step("R8 p0 flushed");
    set_req(2'd0, 16'h6000); step("R8 colliding write dropped");
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) != 0) set_req(2'($urandom), 16'($urandom));
      if ($urandom_range(0, 2) == 0)
        set_wr(int'($urandom_range(0, N_PG-1)), int'($urandom_range(0, 255)),
               1'($urandom), 3'($urandom));
      if ($urandom_range(0, 60) == 0) flush_i = 1;
      step("R9 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule